// File: doc/BRIEF.md
# Peripheral Flash Bus Bridge

This block connects a 32-bit internal request/response port to a slow external bus for flash memories and simple peripherals. The external bus has separate address and data pins. Each request carries a read/write flag, a byte address, a byte count and, for writes, a data word. The bridge finds the address window that holds the address and asserts that window's chip enable. It then runs a sequence of timed transfers, each 8 or 16 bits wide as set for that window. It returns read bytes as packed 32-bit words, and it returns one completion for a write.

Long reads are split into bursts of a bounded number of transfers. The chip enable is released for one cycle between bursts. Writes are confined to one aligned 32-bit word. Any request that cannot be served is answered with an error flag and starts no external cycle. Only one request is handled at a time.

Top module: `pfb_bridge`

## Requirements
- R1: After reset `req_ready` is 1, `ext_ce` is 0 and `rsp_valid` is 0. A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the acceptance of a served request until the cycle in which its final response is presented, so it is never 1 while a chip enable is active.
- R2: A window i covers the addresses base_i <= addr <= limit_i. The lowest-numbered covering window is used, and only its `ext_ce` bit (bit i) is ever asserted. The external address is the request byte address minus that window's base, truncated to 25 bits.
- R3: A request whose address lies in no window produces exactly one response with `rsp_err`=1 and `rsp_last`=1, and no chip enable is asserted.
- R4: A write whose byte count is 0, or whose low address bits plus byte count exceed 4 (more than 4 bytes, or crossing an aligned 4-byte word), produces the same error response and no chip enable. A read with byte count 0 does the same.
- R5: Each transfer holds `ext_addr`, `ext_ce`, `ext_be` and the strobe for `cfg_wait` consecutive cycles. `ext_oe` is 1 during reads and `ext_we` is 1 during writes, and the two are never 1 together.
- R6: Chip enable stays active without a break across at most 4 transfers (one burst). Between the bursts of one request it is 0 for exactly one cycle.
- R7: In an 8-bit window, every byte of the request takes one transfer at consecutive byte addresses. `ext_be` is 01 and data uses bits [7:0].
- R8: In a 16-bit window, transfers go to even addresses only, from the halfword holding the first byte up to the halfword holding the last. Bits [7:0] carry the even byte and bits [15:8] the odd byte. Read bytes outside the request are dropped. For writes, `ext_be` bit 0 or 1 marks whether the even or odd byte belongs to the request. Reads drive `ext_be`=11.
- R9: Read byte k of the request is returned in response word k/4, bits [8*(k%4)+7 : 8*(k%4)]. Lanes past the last byte are 0. There are ceil(len/4) responses, with `rsp_last`=1 on the final one only, even when the final 16-bit transfer completes one word and starts the next.
- R10: Write byte i is taken from `req_wdata` lane (addr[1:0]+i) mod 4. After the last write transfer, one response with `rsp_err`=0 and `rsp_last`=1 follows.
- R11: The bus width is taken from the window's own `cfg_win_wide` bit (1 = 16-bit, 0 = 8-bit), so two windows can use different widths.
- R12: A `cfg_wait` of 0 acts as 1, giving single-cycle transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_win_base | input | NWIN*AW | Window base addresses, window i in bits [i*AW +: AW] |
| cfg_win_limit | input | NWIN*AW | Window inclusive upper addresses |
| cfg_win_wide | input | NWIN | Per window: 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_wait | input | WAITW | Cycles per transfer (0 treated as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request byte address |
| req_len | input | LENW | Request byte count |
| req_wdata | input | DW | Write data, lane = byte address mod 4 |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | DW | Packed read data |
| rsp_last | output | 1 | Final response of the request |
| rsp_err | output | 1 | Address error |
| ext_ce | output | NWIN | Chip enables, active high |
| ext_oe | output | 1 | Output enable (read strobe) |
| ext_we | output | 1 | Write enable |
| ext_addr | output | EAW | External byte address |
| ext_be | output | 2 | External byte strobes |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |

## Verification
The hardest case to reach is a read on a 16-bit window whose final halfword fills one response word and also carries a byte for the next one. The bridge then has to emit two words in a row and must keep `req_ready` low for the extra cycle. The stimulus reaches it with a read that starts at an odd address and has a byte count of 5. A read of 32 bytes and a 5-byte read in an 8-bit window cover the splitting into bursts and the one-cycle chip-enable gap. Windows that overlap and a zero wait setting cover window priority and the shortest transfer timing.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_GAP  = 2'd2
   } pfb_state_e;
endpackage

// File: rtl/pfb_win_dec.sv
module pfb_win_dec #(
   parameter int AW   = 32,
   parameter int EAW  = 25,
   parameter int NWIN = 2
) (
   input  logic [AW-1:0]      addr,
   input  logic [NWIN*AW-1:0] base,
   input  logic [NWIN*AW-1:0] limit,
   input  logic [NWIN-1:0]    wide_in,
   output logic               hit,
   output logic [NWIN-1:0]    sel,
   output logic               wide,
   output logic [EAW-1:0]     offs
);
   logic [NWIN-1:0] match;
   logic [EAW-1:0]  diff [NWIN];

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      assign match[g] = (addr >= base[g*AW +: AW]) && (addr <= limit[g*AW +: AW]);
      assign diff[g]  = addr[EAW-1:0] - base[g*AW +: EAW];
   end

   // descending scan: the lowest matching index is written last and wins
   always_comb begin
      hit  = 1'b0;
      sel  = '0;
      wide = 1'b0;
      offs = '0;
      for (int i = NWIN-1; i >= 0; i--) begin
         if (match[i]) begin
            hit    = 1'b1;
            sel    = '0;
            sel[i] = 1'b1;
            wide   = wide_in[i];
            offs   = diff[i];
         end
      end
   end
endmodule

// File: rtl/pfb_pack.sv
module pfb_pack #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          fin,
   input  logic          b0v,
   input  logic [7:0]    b0,
   input  logic          b1v,
   input  logic [7:0]    b1,
   output logic          o_v,
   output logic [DW-1:0] o_w,
   output logic          o_last,
   output logic          pend
);
   localparam int NB = DW / 8;
   localparam int CW = $clog2(NB) + 1;

   logic [DW-1:0] acc;
   logic [CW-1:0] cnt, newcnt;
   logic [1:0]    n;
   logic [7:0]    first;
   logic [DW+7:0] mix;

   always_comb begin
      n     = {1'b0, b0v} + {1'b0, b1v};
      first = b0v ? b0 : b1;
      mix   = {8'h00, acc};
      if (push && n != 2'd0) mix[{cnt, 3'b000} +: 8] = first;
      if (push && n == 2'd2) mix[{cnt + CW'(1), 3'b000} +: 8] = b1;
      newcnt = cnt + CW'(n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0; cnt <= '0; pend <= 1'b0;
         o_v <= 1'b0; o_w <= '0; o_last <= 1'b0;
      end else begin
         o_v    <= 1'b0;
         o_last <= 1'b0;
         if (clr) begin
            acc <= '0; cnt <= '0; pend <= 1'b0;
         end else if (pend) begin
            o_v <= 1'b1; o_w <= acc; o_last <= 1'b1;
            acc <= '0; cnt <= '0; pend <= 1'b0;
         end else if (push) begin
            if (newcnt >= CW'(NB)) begin
               o_v    <= 1'b1;
               o_w    <= mix[DW-1:0];
               o_last <= fin && (newcnt == CW'(NB));
               acc    <= {{(DW-8){1'b0}}, mix[DW+7:DW]};
               cnt    <= newcnt - CW'(NB);
               pend   <= fin && (newcnt > CW'(NB));
            end else if (fin) begin
               o_v <= 1'b1; o_w <= mix[DW-1:0]; o_last <= 1'b1;
               acc <= '0; cnt <= '0;
            end else begin
               acc <= mix[DW-1:0];
               cnt <= newcnt;
            end
         end
      end
   end

   // R9: a spilled byte is flushed in the very next cycle as the final word
   p_flush_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> (o_v && o_last && !pend));
   // R9: the accumulator never holds more than one word of bytes
   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(NB));
endmodule

// File: rtl/pfb_bridge.sv
module pfb_bridge
   import pfb_pkg::*;
#(
   parameter int AW       = 32,
   parameter int EAW      = 25,
   parameter int NWIN     = 2,
   parameter int LENW     = 6,
   parameter int MAXBURST = 4,
   parameter int WAITW    = 4,
   parameter int DW       = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NWIN*AW-1:0] cfg_win_base,
   input  logic [NWIN*AW-1:0] cfg_win_limit,
   input  logic [NWIN-1:0]    cfg_win_wide,
   input  logic [WAITW-1:0]   cfg_wait,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [AW-1:0]      req_addr,
   input  logic [LENW-1:0]    req_len,
   input  logic [DW-1:0]      req_wdata,
   output logic               rsp_valid,
   output logic [DW-1:0]      rsp_rdata,
   output logic               rsp_last,
   output logic               rsp_err,
   output logic [NWIN-1:0]    ext_ce,
   output logic               ext_oe,
   output logic               ext_we,
   output logic [EAW-1:0]     ext_addr,
   output logic [1:0]         ext_be,
   output logic [15:0]        ext_wdata,
   input  logic [15:0]        ext_rdata
);
   localparam int BCW = $clog2(MAXBURST + 1);

   initial begin : g_param_chk
      assert (DW == 32) else $error("pfb_bridge: DW must be 32");
      assert (NWIN >= 1) else $error("pfb_bridge: NWIN must be at least 1");
      assert (EAW > LENW && EAW <= AW) else $error("pfb_bridge: bad EAW");
      assert (MAXBURST >= 1) else $error("pfb_bridge: MAXBURST must be positive");
   end

   pfb_state_e       st;
   logic             dec_hit, dec_wide, len_ok, bad, acc;
   logic [NWIN-1:0]  dec_sel, sel_q;
   logic [EAW-1:0]   dec_offs, len_ext, xa, xa_top, lo, hi;
   logic [LENW:0]    wr_span;
   logic             wide_q, wr_q, xend, lastx, b0v, b1v;
   logic [1:0]       lane0, d_lo, d_hi;
   logic [DW-1:0]    wd_q, pk_w;
   logic [WAITW-1:0] wlim, wcnt;
   logic [BCW-1:0]   bcnt;
   logic             ctl_v, ctl_err, pk_v, pk_last, pk_pend;

   pfb_win_dec #(.AW(AW), .EAW(EAW), .NWIN(NWIN)) u_dec (
      .addr(req_addr), .base(cfg_win_base), .limit(cfg_win_limit),
      .wide_in(cfg_win_wide), .hit(dec_hit), .sel(dec_sel),
      .wide(dec_wide), .offs(dec_offs)
   );

   // request legality
   assign len_ext = {{(EAW-LENW){1'b0}}, req_len};
   assign wr_span = {1'b0, req_len} + {{(LENW-1){1'b0}}, req_addr[1:0]};
   assign len_ok  = (req_len != '0) && (!req_write || wr_span <= (LENW+1)'(4));
   assign bad     = !dec_hit || !len_ok;
   assign req_ready = (st == ST_IDLE) && !pk_pend;
   assign acc     = req_valid && req_ready;

   // transfer progress
   assign xa_top = xa + (wide_q ? EAW'(1) : EAW'(0));
   assign xend   = (st == ST_XFER) && (wcnt == wlim);
   assign lastx  = xa_top >= hi;
   assign b0v    = !wide_q || (xa >= lo);
   assign b1v    = wide_q && (xa_top <= hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; sel_q <= '0; wide_q <= 1'b0; wr_q <= 1'b0;
         xa <= '0; lo <= '0; hi <= '0; lane0 <= '0; wd_q <= '0;
         wlim <= WAITW'(1); wcnt <= WAITW'(1); bcnt <= '0;
         ctl_v <= 1'b0; ctl_err <= 1'b0;
      end else begin
         ctl_v   <= 1'b0;
         ctl_err <= 1'b0;
         case (st)
            ST_IDLE: if (acc) begin
               if (bad) begin
                  ctl_v <= 1'b1; ctl_err <= 1'b1;
               end else begin
                  st     <= ST_XFER;
                  sel_q  <= dec_sel;
                  wide_q <= dec_wide;
                  wr_q   <= req_write;
                  lo     <= dec_offs;
                  hi     <= dec_offs + len_ext - EAW'(1);
                  xa     <= dec_wide ? {dec_offs[EAW-1:1], 1'b0} : dec_offs;
                  lane0  <= req_addr[1:0];
                  wd_q   <= req_wdata;
                  wlim   <= (cfg_wait == '0) ? WAITW'(1) : cfg_wait;
                  wcnt   <= WAITW'(1);
                  bcnt   <= '0;
               end
            end
            ST_XFER: if (xend) begin
               if (lastx) begin
                  st    <= ST_IDLE;
                  ctl_v <= wr_q;
               end else begin
                  xa   <= xa + (wide_q ? EAW'(2) : EAW'(1));
                  wcnt <= WAITW'(1);
                  if (bcnt == BCW'(MAXBURST - 1)) begin
                     bcnt <= '0;
                     st   <= ST_GAP;
                  end else begin
                     bcnt <= bcnt + BCW'(1);
                  end
               end
            end else begin
               wcnt <= wcnt + WAITW'(1);
            end
            default: st <= ST_XFER;
         endcase
      end
   end

   pfb_pack #(.DW(DW)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(acc), .push(xend && !wr_q), .fin(lastx),
      .b0v(b0v), .b0(ext_rdata[7:0]), .b1v(b1v), .b1(ext_rdata[15:8]),
      .o_v(pk_v), .o_w(pk_w), .o_last(pk_last), .pend(pk_pend)
   );

   // write lane selection: lane of byte b is lane0 + (b - lo)
   always_comb begin
      d_lo = lane0 + 2'(xa - lo);
      d_hi = d_lo + 2'd1;
      if (wide_q) ext_wdata = {wd_q[{d_hi, 3'b000} +: 8], wd_q[{d_lo, 3'b000} +: 8]};
      else        ext_wdata = {8'h00, wd_q[{d_lo, 3'b000} +: 8]};
      if (!wide_q)   ext_be = 2'b01;
      else if (wr_q) ext_be = {b1v, b0v};
      else           ext_be = 2'b11;
   end

   assign ext_ce    = (st == ST_XFER) ? sel_q : '0;
   assign ext_oe    = (st == ST_XFER) && !wr_q;
   assign ext_we    = (st == ST_XFER) && wr_q;
   assign ext_addr  = xa;
   assign rsp_valid = ctl_v || pk_v;
   assign rsp_last  = ctl_v || pk_last;
   assign rsp_err   = ctl_err;
   assign rsp_rdata = pk_v ? pk_w : '0;

   // independent count of completed transfers within one chip-enable run
   logic [BCW:0] run_n;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run_n <= '0;
      else if (ext_ce == '0)    run_n <= '0;
      else if (xend)            run_n <= run_n + (BCW+1)'(1);
   end

   p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_ce != '0) |-> !req_ready);
   p_ce_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ext_ce));
   p_unmapped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !dec_hit) |=> (ext_ce == '0) && rsp_valid && rsp_err);
   p_badlen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !len_ok) |=> (ext_ce == '0) && rsp_valid && rsp_err);
   p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_oe && ext_we));
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_XFER) && !xend) |=> $stable(ext_addr) && $stable(ext_ce) && $stable(ext_be));
   p_burst_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run_n <= (BCW+1)'(MAXBURST));
   p_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ext_ce != '0) && wide_q) |-> !ext_addr[0]);
   p_wrdone_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xend && lastx && wr_q) |=> rsp_valid && rsp_last && !rsp_err);
endmodule

// File: tb/sim_pfb_bridge.sv
module sim_pfb_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cfg_win_base, cfg_win_limit;
   logic [1:0]  cfg_win_wide;
   logic [3:0]  cfg_wait;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [5:0]  req_len = '0;
   logic        req_ready, rsp_valid, rsp_last, rsp_err, ext_oe, ext_we;
   logic [31:0] rsp_rdata;
   logic [1:0]  ext_ce, ext_be;
   logic [24:0] ext_addr;
   logic [15:0] ext_wdata, ext_rdata;

   always #5 clk = ~clk;

   pfb_bridge u0 (
      .clk(clk), .rst_n(rst_n), .cfg_win_base(cfg_win_base), .cfg_win_limit(cfg_win_limit),
      .cfg_win_wide(cfg_win_wide), .cfg_wait(cfg_wait), .req_valid(req_valid),
      .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_last(rsp_last), .rsp_err(rsp_err), .ext_ce(ext_ce), .ext_oe(ext_oe),
      .ext_we(ext_we), .ext_addr(ext_addr), .ext_be(ext_be), .ext_wdata(ext_wdata),
      .ext_rdata(ext_rdata)
   );

   // device model: byte value depends on address and on which chip enable is active
   function automatic logic [7:0] dev_byte(input logic [24:0] a, input logic w1);
      return a[7:0] ^ 8'h5A ^ (w1 ? 8'hC3 : 8'h00);
   endfunction
   assign ext_rdata = {dev_byte(ext_addr + 25'd1, ext_ce[1]), dev_byte(ext_addr, ext_ce[1])};

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // bus monitor
   int          cyc = 0, ce_cyc, bursts, first_c, last_c, busy_bad, both_bad, nx, nr;
   logic [1:0]  ce_or, prev_ce;
   logic [24:0] prev_addr;
   logic [24:0] x_addr [32];
   logic [1:0]  x_be   [32];
   logic [15:0] x_dat  [32];
   logic        x_we   [32];
   logic [31:0] r_dat  [16];
   logic        r_last [16];
   logic        r_err  [16];

   task automatic clr_log();
      ce_cyc = 0; bursts = 0; first_c = -1; last_c = -1; busy_bad = 0; both_bad = 0;
      nx = 0; nr = 0; ce_or = '0;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (ext_ce != '0) begin
            ce_cyc++;
            ce_or = ce_or | ext_ce;
            if (first_c < 0) first_c = cyc;
            last_c = cyc;
            if (prev_ce == '0) bursts++;
            if ((prev_ce == '0 || ext_addr != prev_addr) && nx < 32) begin
               x_addr[nx] = ext_addr; x_be[nx] = ext_be; x_dat[nx] = ext_wdata; x_we[nx] = ext_we;
               nx++;
            end
            if (req_ready) busy_bad++;
         end
         if (ext_oe && ext_we) both_bad++;
         if (rsp_valid && nr < 16) begin
            r_dat[nr] = rsp_rdata; r_last[nr] = rsp_last; r_err[nr] = rsp_err; nr++;
         end
      end
      prev_ce = ext_ce;
      prev_addr = ext_addr;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input bit wr, input logic [31:0] a, input int len, input logic [31:0] wd);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      clr_log();
      req_valid = 1'b1; req_write = wr; req_addr = a; req_len = 6'(len); req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      while (!req_ready) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] exp_word(input int off, input int j, input int len, input bit w1);
      logic [31:0] v = '0;
      for (int l = 0; l < 4; l++)
         if (4*j + l < len) v[8*l +: 8] = dev_byte(25'(off + 4*j + l), w1);
      return v;
   endfunction

   // read checks: responses, transfer addresses, timing, bursts
   task automatic check_read(input string tag, input int off, input int len, input bit w1,
                             input int x0, input int step, input int nxe, input int nbe,
                             input int wt, input logic [1:0] ceb);
      int nw = (len + 3) / 4;
      chk({tag, " response count"}, nr, nw);
      for (int j = 0; j < nw && j < nr; j++) begin
         chk({tag, " R9 word data"}, r_dat[j], exp_word(off, j, len, w1));
         chk({tag, " R9 last flag"}, 32'(r_last[j]), 32'(j == nw - 1));
         chk({tag, " R3 no error"}, 32'(r_err[j]), 0);
      end
      chk({tag, " transfer count"}, nx, nxe);
      for (int k = 0; k < nx && k < nxe; k++) begin
         chk({tag, " R2 transfer address"}, 32'(x_addr[k]), 32'(x0 + k*step));
         chk({tag, " byte strobes"}, 32'(x_be[k]), (step == 2) ? 32'd3 : 32'd1);
      end
      chk({tag, " R5 cycles under chip enable"}, ce_cyc, nxe * wt);
      chk({tag, " R6 bursts"}, bursts, nbe);
      chk({tag, " R6 one-cycle gaps"}, last_c - first_c + 1, ce_cyc + nbe - 1);
      chk({tag, " R2 chip enable select"}, 32'(ce_or), 32'(ceb));
      chk({tag, " R1 ready low while busy"}, busy_bad, 0);
      chk({tag, " R5 strobes exclusive"}, both_bad, 0);
   endtask

   task automatic check_err(input string tag);
      chk({tag, " single response"}, nr, 1);
      chk({tag, " error flag"}, 32'(r_err[0]), 1);
      chk({tag, " last flag"}, 32'(r_last[0]), 1);
      chk({tag, " no chip enable"}, ce_cyc, 0);
   endtask

   task automatic t_reset();
      chk("R1 reset ready", 32'(req_ready), 1);
      chk("R1 reset chip enable", 32'(ext_ce), 0);
      chk("R1 reset rsp_valid", 32'(rsp_valid), 0);
   endtask

   task automatic t_long_read16();   // R6 R8 R9: 32 bytes, 4 bursts of 4 halfwords
      send(1'b0, 32'h1000_0040, 32, '0);
      check_read("R8 long read", 'h40, 32, 1'b0, 'h40, 2, 16, 4, 2, 2'b01);
   endtask

   task automatic t_read8();         // R7 R11: 8-bit window, 2 bursts
      send(1'b0, 32'h2000_0011, 5, '0);
      check_read("R7 byte read", 'h11, 5, 1'b1, 'h11, 1, 5, 2, 2, 2'b10);
   endtask

   task automatic t_unaligned16();   // R8: unwanted bytes at both ends dropped
      send(1'b0, 32'h1000_0003, 6, '0);
      check_read("R8 unaligned read", 3, 6, 1'b0, 2, 2, 4, 1, 2, 2'b01);
   endtask

   task automatic t_spill16();       // R9: final halfword completes a word and spills one byte
      send(1'b0, 32'h1000_0001, 5, '0);
      check_read("R9 spill read", 1, 5, 1'b0, 0, 2, 3, 1, 2, 2'b01);
   endtask

   task automatic t_write16();       // R8 R10
      send(1'b1, 32'h1000_0101, 2, 32'hAABB_CCDD);
      chk("R10 write transfers", nx, 2);
      chk("R8 write strobes 0", 32'(x_be[0]), 32'd2);
      chk("R8 write addr 0", 32'(x_addr[0]), 32'h100);
      chk("R10 write odd byte", 32'(x_dat[0][15:8]), 32'hCC);
      chk("R8 write strobes 1", 32'(x_be[1]), 32'd1);
      chk("R10 write even byte", 32'(x_dat[1][7:0]), 32'hBB);
      chk("R5 write uses we", 32'(x_we[0]), 1);
      chk("R10 write response", nr, 1);
      chk("R10 write ok flags", {30'b0, r_err[0], r_last[0]}, 32'd1);
      chk("R5 write cycles", ce_cyc, 4);
   endtask

   task automatic t_write8();        // R7 R10
      send(1'b1, 32'h2000_0020, 4, 32'h4433_2211);
      chk("R7 write transfers", nx, 4);
      for (int k = 0; k < 4 && k < nx; k++) begin
         chk("R7 write address", 32'(x_addr[k]), 32'h20 + k);
         chk("R10 write byte", 32'(x_dat[k][7:0]), 32'(8'h11 * (k + 1)));
         chk("R7 write strobe", 32'(x_be[k]), 1);
      end
      chk("R10 write8 response", {30'b0, r_err[0], r_last[0]}, 32'd1);
   endtask

   task automatic t_errors();        // R3 R4
      send(1'b1, 32'h1000_0002, 3, 32'h0);  check_err("R4 crossing write");
      send(1'b1, 32'h1000_0000, 5, 32'h0);  check_err("R4 oversize write");
      send(1'b1, 32'h1000_0000, 0, 32'h0);  check_err("R4 empty write");
      send(1'b0, 32'h1000_0000, 0, 32'h0);  check_err("R4 empty read");
      send(1'b0, 32'h3000_0000, 4, 32'h0);  check_err("R3 unmapped read");
      send(1'b1, 32'h0FFF_FFFF, 1, 32'h0);  check_err("R3 unmapped write");
   endtask

   task automatic t_waits();         // R5 R12
      cfg_wait = 4'd0;
      send(1'b0, 32'h2000_0030, 4, '0);
      check_read("R12 zero wait", 'h30, 4, 1'b1, 'h30, 1, 4, 1, 1, 2'b10);
      cfg_wait = 4'd5;
      send(1'b0, 32'h1000_0200, 2, '0);
      check_read("R5 five waits", 'h200, 2, 1'b0, 'h200, 2, 1, 1, 5, 2'b01);
      cfg_wait = 4'd2;
   endtask

   task automatic t_priority();      // R2: overlapping windows, lower index wins
      cfg_win_base[63:32]  = 32'h1000_0400;
      cfg_win_limit[63:32] = 32'h1000_FFFF;
      send(1'b0, 32'h1000_0500, 2, '0);
      check_read("R2 overlap", 'h500, 2, 1'b0, 'h500, 2, 1, 1, 2, 2'b01);
      cfg_win_base[63:32]  = 32'h2000_0000;
      cfg_win_limit[63:32] = 32'h2000_FFFF;
   endtask

   initial begin
      cfg_win_base  = {32'h2000_0000, 32'h1000_0000};
      cfg_win_limit = {32'h2000_FFFF, 32'h10FF_FFFF};
      cfg_win_wide  = 2'b01;
      cfg_wait      = 4'd2;
      clr_log();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_long_read16();
      t_read8();
      t_unaligned16();
      t_spill16();
      t_write16();
      t_write8();
      t_errors();
      t_waits();
      t_priority();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule